// File: doc/BRIEF.md
# Configuration Unlock and Register Front End

This block sits at the front of a legacy multi-function I/O controller and owns its configuration space. A host reaches it over a simple bus (address, write data, write strobe, read strobe, read data) through two byte ports: a select port at 0x3F0 and a data port at 0x3F1. Until a fixed byte key has been written twice to the select port, the configuration space is closed. Data-port writes are then dropped and every read returns zero.

Once the space is open, a byte written to the select port chooses one of sixteen 8-bit configuration registers. The one exception is the close key 0xAA, which shuts the space again. A write to the data port stores into the chosen register, and a read of the data port returns it.

The three lowest registers are driven out continuously to a resource decoder. Every accepted data write is reported one cycle later with a strobe, the register number and a mask of the bits that changed. This lets downstream logic rework only the fields that moved.

Top module: `sio_cfg_frontend`

## Requirements
- R1: After reset the space is closed (`cfg_open` = 0), the select register is 0, register 0 holds 0x3F, register 1 holds 0x9F, register 2 holds 0xDC and registers 3 to 15 hold 0x00.
- R2: While closed, two writes of 0x55 to address 0x3F0 open the space; `cfg_open` is 1 in the cycle after the clock edge that takes the second one.
- R3: While closed, a write to 0x3F0 of any value other than 0x55 neither advances nor clears the count of 0x55 writes already seen.
- R4: While closed, a write to 0x3F1 changes no register and produces no change strobe.
- R5: While open, writing 0xAA to 0x3F0 closes the space and clears the count, so one further 0x55 does not reopen it.
- R6: While open, any other byte written to 0x3F0 becomes the select value; a write to 0x3F1 stores its byte into the selected register, and a read of 0x3F1 returns that register combinationally while `rd_en` is high.
- R7: While open with a select value of 16 or more, a write to 0x3F1 is ignored (no register changes, no strobe) and a read of 0x3F1 returns 0x00.
- R8: A read of 0x3F0, and any read while closed, returns 0x00.
- R9: Each accepted data write raises `chg_stb` for exactly the next cycle, with `chg_idx` holding the register number and `chg_mask` holding the old value XOR the new value.
- R10: `cfg_r0`, `cfg_r1` and `cfg_r2` always show the current contents of registers 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one transfer per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, zero when not selected |
| cfg_open | output | 1 | Configuration space is open |
| cfg_r0 | output | 8 | Register 0 contents |
| cfg_r1 | output | 8 | Register 1 contents |
| cfg_r2 | output | 8 | Register 2 contents |
| chg_stb | output | 1 | One-cycle pulse after an accepted data write |
| chg_idx | output | 4 | Register number of the reported write |
| chg_mask | output | 8 | Bits changed by the reported write |

## Verification
The hardest state to reach from the ports is a half-finished unlock that has been interleaved with other traffic. One case is a single key byte followed by a foreign byte, then a second key byte. Another is a close followed by a lone key byte, where a stale count would wrongly reopen the space. The stimulus table builds these sequences explicitly. It then reads back registers through the data port afterwards to show that locked-mode writes left them untouched. Directed tests cover the change strobe and out-of-range selects.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int NREG   = 16;
  localparam int DW     = 8;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_t;

  function automatic logic [DW-1:0] reg_default(input int idx);
    case (idx)
      0:       reg_default = 8'h3F;
      1:       reg_default = 8'h9F;
      2:       reg_default = 8'hDC;
      default: reg_default = '0;
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_lock.sv
module sio_cfg_lock
  import sio_cfg_pkg::*;
#(
  parameter logic [DW-1:0] OPEN_KEY  = 8'h55,
  parameter logic [DW-1:0] CLOSE_KEY = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic [DW-1:0] wdata,
  output logic          open_o,
  output logic          sel_load
);
  lock_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    sel_load = 1'b0;
    if (sel_wr) begin
      case (state_q)
        LK_IDLE: if (wdata == OPEN_KEY) state_d = LK_HALF;
        LK_HALF: if (wdata == OPEN_KEY) state_d = LK_OPEN;
        LK_OPEN: begin
          if (wdata == CLOSE_KEY) state_d = LK_IDLE;
          else                    sel_load = 1'b1;
        end
        default: state_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_IDLE;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == LK_OPEN);
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
  import sio_cfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [RIDX_W-1:0]         wr_idx,
  input  logic [DW-1:0]             wdata,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] RST_VAL = reg_default(g);
    logic hit;
    assign hit = wr_en && (wr_idx == RIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_o[g] <= RST_VAL;
      else if (hit) regs_o[g] <= wdata;
    end
  end
endmodule

// File: rtl/sio_cfg_change.sv
module sio_cfg_change
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [DW-1:0]     old_val,
  input  logic [DW-1:0]     new_val,
  output logic              stb_o,
  output logic [RIDX_W-1:0] idx_o,
  output logic [DW-1:0]     mask_o
);
  logic [DW-1:0] mask_d;
  assign mask_d = old_val ^ new_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_o <= 1'b0;
    else        stb_o <= wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o  <= '0;
      mask_o <= '0;
    end else if (wr_en) begin
      idx_o  <= wr_idx;
      mask_o <= mask_d;
    end
  end
endmodule

// File: rtl/sio_cfg_frontend.sv
module sio_cfg_frontend
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SEL_PORT  = 16'h03F0,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h03F1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              cfg_open,
  output logic [7:0]        cfg_r0,
  output logic [7:0]        cfg_r1,
  output logic [7:0]        cfg_r2,
  output logic              chg_stb,
  output logic [3:0]        chg_idx,
  output logic [7:0]        chg_mask
);
  logic                    sel_wr, data_wr, sel_load, idx_ok, acc_wr;
  logic [DW-1:0]           sel_q;
  logic [RIDX_W-1:0]       sel_idx;
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           cur_val;

  assign sel_wr  = bus_wr && (bus_addr == SEL_PORT);
  assign data_wr = bus_wr && (bus_addr == DATA_PORT);
  assign sel_idx = sel_q[RIDX_W-1:0];
  assign idx_ok  = (sel_q[DW-1:RIDX_W] == '0);
  assign acc_wr  = data_wr && cfg_open && idx_ok;

  sio_cfg_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_wr   (sel_wr),
    .wdata    (bus_wdata),
    .open_o   (cfg_open),
    .sel_load (sel_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= '0;
    else if (sel_load) sel_q <= bus_wdata;
  end

  sio_cfg_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (acc_wr),
    .wr_idx (sel_idx),
    .wdata  (bus_wdata),
    .regs_o (regs)
  );

  assign cur_val = regs[sel_idx];

  sio_cfg_change u_chg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_wr),
    .wr_idx  (sel_idx),
    .old_val (cur_val),
    .new_val (bus_wdata),
    .stb_o   (chg_stb),
    .idx_o   (chg_idx),
    .mask_o  (chg_mask)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && (bus_addr == DATA_PORT) && cfg_open && idx_ok)
      bus_rdata = cur_val;
  end

  assign cfg_r0 = regs[0];
  assign cfg_r1 = regs[1];
  assign cfg_r2 = regs[2];
endmodule

// File: rtl/sio_cfg_frontend_chk.sv
module sio_cfg_frontend_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic        cfg_open,
  input logic [7:0]  cfg_r0,
  input logic        chg_stb,
  input logic [3:0]  chg_idx
);
  p_open_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(bus_wr && bus_addr == 16'h03F0 && bus_wdata == 8'h55));

  p_close_by_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(bus_wr && bus_addr == 16'h03F0 && bus_wdata == 8'hAA));

  p_no_stb_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> $past(cfg_open && bus_wr && bus_addr == 16'h03F1));

  p_closed_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !cfg_open) |-> bus_rdata == 8'h00);

  p_r0_export_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_stb && chg_idx == 4'd0) |-> cfg_r0 == $past(bus_wdata));
endmodule

bind sio_cfg_frontend sio_cfg_frontend_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .cfg_open  (cfg_open),
  .cfg_r0    (cfg_r0),
  .chg_stb   (chg_stb),
  .chg_idx   (chg_idx)
);

// File: tb/sio_cfg_frontend_test.sv
module sio_cfg_frontend_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata, cfg_r0, cfg_r1, cfg_r2, chg_mask;
  logic        cfg_open, chg_stb;
  logic [3:0]  chg_idx;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic       s_stb;
  logic [3:0] s_idx;
  logic [7:0] s_mask;

  always #4 clk = ~clk;

  sio_cfg_frontend uut (.*);

  localparam logic [15:0] SP = 16'h03F0, DP = 16'h03F1;
  // {op(4): 0=write 1=read-check, req(4), addr(16), data(8), expected(8)}
  localparam int NV = 29;
  localparam logic [39:0] VEC [NV] = '{
    {4'd1, 4'd8, DP, 8'h00, 8'h00}, // R8 closed read
    {4'd0, 4'd4, DP, 8'h77, 8'h00}, // R4 closed data write dropped
    {4'd0, 4'd2, SP, 8'h55, 8'h00}, // R2 first key
    {4'd0, 4'd3, SP, 8'h12, 8'h00}, // R3 foreign byte keeps count
    {4'd1, 4'd3, DP, 8'h00, 8'h00}, // R3 still closed
    {4'd0, 4'd2, SP, 8'h55, 8'h00}, // R2 second key opens
    {4'd0, 4'd6, SP, 8'h00, 8'h00},
    {4'd1, 4'd1, DP, 8'h00, 8'h3F}, // R1 default reg0, R4 untouched
    {4'd1, 4'd8, SP, 8'h00, 8'h00}, // R8 select port reads zero
    {4'd0, 4'd6, SP, 8'h01, 8'h00},
    {4'd1, 4'd1, DP, 8'h00, 8'h9F}, // R1 reg1
    {4'd0, 4'd6, SP, 8'h02, 8'h00},
    {4'd1, 4'd1, DP, 8'h00, 8'hDC}, // R1 reg2
    {4'd0, 4'd6, SP, 8'h05, 8'h00},
    {4'd1, 4'd1, DP, 8'h00, 8'h00}, // R1 reg5 zero
    {4'd0, 4'd6, DP, 8'hA5, 8'h00},
    {4'd1, 4'd6, DP, 8'h00, 8'hA5}, // R6 store and read back
    {4'd0, 4'd7, SP, 8'h14, 8'h00},
    {4'd0, 4'd7, DP, 8'h33, 8'h00}, // R7 out of range write
    {4'd1, 4'd7, DP, 8'h00, 8'h00}, // R7 out of range read
    {4'd0, 4'd6, SP, 8'h0F, 8'h00},
    {4'd0, 4'd6, DP, 8'hC3, 8'h00},
    {4'd1, 4'd6, DP, 8'h00, 8'hC3}, // R6 top register
    {4'd0, 4'd5, SP, 8'hAA, 8'h00}, // R5 close
    {4'd0, 4'd4, DP, 8'h11, 8'h00}, // R4 closed write to reg15
    {4'd0, 4'd2, SP, 8'h55, 8'h00},
    {4'd0, 4'd2, SP, 8'h55, 8'h00},
    {4'd1, 4'd4, DP, 8'h00, 8'hC3}, // R4 reg15 unchanged
    {4'd0, 4'd5, SP, 8'hAA, 8'h00}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp_v, input string what);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp_v);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    s_stb = chg_stb; s_idx = chg_idx; s_mask = chg_mask;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state at the ports
    check(1, {7'd0, cfg_open}, 8'h00, "closed after reset");
    check(1, cfg_r0, 8'h3F, "reg0 default");
    check(1, cfg_r1, 8'h9F, "reg1 default");
    check(1, cfg_r2, 8'hDC, "reg2 default");
    check(9, {7'd0, chg_stb}, 8'h00, "no strobe after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39:36] == 4'd0) wr(VEC[i][31:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][31:16], v);
        check(int'(VEC[i][35:32]), v, VEC[i][7:0], $sformatf("vector %0d", i));
      end
    end

    // R2 open flag, R1 select resets to 0 (reset, then open, read reg0)
    do_reset();
    wr(SP, 8'h55);
    check(2, {7'd0, cfg_open}, 8'h00, "one key not open");
    wr(SP, 8'h55);
    check(2, {7'd0, cfg_open}, 8'h01, "open after two keys");
    rd(DP, v);
    check(1, v, 8'h3F, "select resets to reg0");

    // R9 / R10 change reporting
    wr(SP, 8'h01);
    wr(DP, 8'h90);
    check(9, {7'd0, s_stb}, 8'h01, "strobe after write");
    check(9, {4'd0, s_idx}, 8'h01, "strobe index");
    check(9, s_mask, 8'h0F, "change mask");
    check(10, cfg_r1, 8'h90, "reg1 export");
    @(negedge clk);
    check(9, {7'd0, chg_stb}, 8'h00, "strobe one cycle");
    wr(SP, 8'h00);
    wr(DP, 8'h3F);
    check(9, {7'd0, s_stb}, 8'h01, "strobe on unchanged write");
    check(9, s_mask, 8'h00, "zero mask on same value");
    wr(DP, 8'hC0);
    check(9, s_mask, 8'hFF, "full mask");
    check(10, cfg_r0, 8'hC0, "reg0 export");
    wr(SP, 8'h02);
    wr(DP, 8'h5C);
    check(10, cfg_r2, 8'h5C, "reg2 export");
    check(9, s_mask, 8'h80, "reg2 mask");

    // R7 no strobe for out of range select
    wr(SP, 8'hF2);
    wr(DP, 8'h01);
    check(7, {7'd0, s_stb}, 8'h00, "no strobe select>=16");
    check(7, cfg_r2, 8'h5C, "alias reg2 untouched");

    // R5 close clears count; R4 no strobe when closed
    wr(SP, 8'hAA);
    check(5, {7'd0, cfg_open}, 8'h00, "closed by AA");
    wr(DP, 8'h00);
    check(4, {7'd0, s_stb}, 8'h00, "no strobe while closed");
    wr(SP, 8'h55);
    check(5, {7'd0, cfg_open}, 8'h00, "count cleared by close");
    wr(SP, 8'h55);
    check(5, {7'd0, cfg_open}, 8'h01, "reopen needs second key");
    check(4, cfg_r0, 8'hC0, "closed write left reg0");

    done = 1'b1;
    finish_run();
  end
endmodule